// File: doc/BRIEF.md
# SDRAM Auto-Refresh Command Sequencer

This block sits on the controller side of an SDRAM interface and keeps the memory refreshed. A free-running interval timer marks each refresh period. Every period adds one refresh to an owed count. While refreshes are owed, the block raises a request towards the main bus arbiter. The arbiter grants the bus only between bursts.

On a grant the block takes the command pins. If the controller reports that any bank is open, the block first issues a precharge-all command and lets the precharge time pass. It then issues one auto-refresh command for each owed period, spacing them by the row-cycle time. The memory keeps its own refresh row and bank counter, and it restores the row by itself. For that reason no address is driven with a refresh and no precharge follows one. After the last refresh the block waits out the row-cycle time, pulses a done strobe and releases the bus.

All command pins are registered. A pin command appears one clock after the internal sequencer decides to issue it.

Top module: `refresh_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after reset is asserted asynchronously, `csN`, `rasN`, `casN` and `weN` are high, `a10` is low, `cke` is high, and `refReq` and `refDone` are low.
- R2: After reset is released, `refReq` goes high exactly `INTERVAL` clock cycles later, counted as rising edges with `rstN` high. Later refresh periods follow every `INTERVAL` cycles.
- R3: No command is issued, meaning `csN` stays high, unless a grant has been sampled while refreshes are owed. `csN` is low only while `refReq` is high.
- R4: If `bankOpen` is high when the grant is accepted, exactly one precharge-all command comes before the first refresh. Precharge-all is `csN`=0, `rasN`=0, `casN`=1, `weN`=0, `a10`=1. If `bankOpen` is low, no precharge-all is issued.
- R5: The precharge-all command is followed by exactly `T_RP` cycles of no command. The first refresh therefore appears `T_RP`+1 cycles after the precharge-all.
- R6: An auto-refresh command is `csN`=0, `rasN`=0, `casN`=0, `weN`=1, with `a10` low and `cke` high. `cke` stays high at all times.
- R7: Consecutive auto-refresh commands are exactly `T_RC` cycles apart. No command follows a refresh in fewer than `T_RC` cycles.
- R8: If k refresh periods expire before the grant, with k no larger than `MAX_OWED`, exactly k refreshes are issued back to back after a single grant. No precharge is issued between them.
- R9: The owed count saturates at `MAX_OWED`. Periods that expire beyond that limit are dropped.
- R10: `refDone` is a one-cycle pulse. It appears `T_RC`-1 cycles after the last refresh of a burst, and `refReq` is low in that same cycle.
- R11: Once a sequence has started, dropping `refGnt` neither stops nor shortens it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refGnt | input | 1 | Bus grant from the arbiter, sampled while idle |
| bankOpen | input | 1 | High when at least one bank holds an open row |
| refReq | output | 1 | High while refreshes are owed or a sequence runs |
| refDone | output | 1 | One-cycle pulse when the bus is handed back |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, high for precharge-all |
| cke | output | 1 | Clock enable, held high |

## Verification
The bench builds the block with `INTERVAL`=64, `T_RP`=2, `T_RC`=5 and `MAX_OWED`=3. These values keep a full three-refresh burst, with its leading precharge, inside half a refresh period. Each hold-off can then be timed to an exact number of expired periods without a new period landing mid-burst. A five-period hold-off drives the owed count past its limit, and the short `T_RC` makes the back-to-back spacing measurable within a few cycles. A reset issued in the middle of a precharge sequence is also exercised, followed by a fresh timing of the first request.

// File: rtl/refresh_seq_pkg.sv
package refresh_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PRE,
    SEQ_RPWAIT,
    SEQ_REF,
    SEQ_RCWAIT
  } seqState_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic issuePre;
    logic issueRef;
    logic finish;
  } seqStrobe_t;

endpackage

// File: rtl/refresh_seq_ctrl.sv
module refresh_seq_ctrl
  import refresh_seq_pkg::*;
#(
  parameter int T_RP = 3,
  parameter int T_RC = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGnt,
  input  logic       bankOpen,
  input  logic       owedNz,
  output seqStrobe_t strb,
  output logic       busy
);

  localparam int WAIT_MAX = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam logic [WAIT_W-1:0] RP_LOAD = WAIT_W'(T_RP - 1);
  localparam logic [WAIT_W-1:0] RC_LOAD = WAIT_W'(T_RC - 2);

  seqState_t         state, stateNxt;
  logic [WAIT_W-1:0] waitCnt, waitCntNxt;

  always_comb begin
    stateNxt   = state;
    waitCntNxt = waitCnt;
    strb       = '0;
    unique case (state)
      SEQ_IDLE: begin
        if (owedNz && refGnt) stateNxt = bankOpen ? SEQ_PRE : SEQ_REF;
      end
      SEQ_PRE: begin
        strb.issuePre = 1'b1;
        stateNxt      = SEQ_RPWAIT;
        waitCntNxt    = RP_LOAD;
      end
      SEQ_RPWAIT: begin
        if (waitCnt == '0) stateNxt = SEQ_REF;
        else               waitCntNxt = waitCnt - 1'b1;
      end
      SEQ_REF: begin
        strb.issueRef = 1'b1;
        stateNxt      = SEQ_RCWAIT;
        waitCntNxt    = RC_LOAD;
      end
      SEQ_RCWAIT: begin
        if (waitCnt == '0) begin
          if (owedNz) begin
            stateNxt = SEQ_REF;
          end else begin
            stateNxt    = SEQ_IDLE;
            strb.finish = 1'b1;
          end
        end else begin
          waitCntNxt = waitCnt - 1'b1;
        end
      end
      default: stateNxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNxt;
      waitCnt <= waitCntNxt;
    end
  end

  assign busy = (state != SEQ_IDLE);

endmodule

// File: rtl/refresh_seq_dp.sv
module refresh_seq_dp
  import refresh_seq_pkg::*;
#(
  parameter int INTERVAL = 780,
  parameter int MAX_OWED = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic       busy,
  output logic       owedNz,
  output logic       refReq,
  output logic       refDone,
  output logic       csN,
  output logic       rasN,
  output logic       casN,
  output logic       weN,
  output logic       a10,
  output logic       cke
);

  localparam int TMR_W  = ($clog2(INTERVAL) < 1) ? 1 : $clog2(INTERVAL);
  localparam int OWED_W = $clog2(MAX_OWED + 1);
  localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(INTERVAL - 1);
  localparam logic [OWED_W-1:0] OWED_CAP = OWED_W'(MAX_OWED);

  logic [TMR_W-1:0]  tmr;
  logic [OWED_W-1:0] owed;
  logic              tick, addOne, takeOne;

  // refresh period timer
  assign tick = (tmr == TMR_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmr <= '0;
    else       tmr <= tick ? '0 : tmr + 1'b1;
  end

  // owed refresh count, saturating
  assign takeOne = strb.issueRef;
  assign addOne  = tick && ((owed != OWED_CAP) || takeOne);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owed <= '0;
    end else begin
      unique case ({addOne, takeOne})
        2'b10:   owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assign owedNz = (owed != '0);
  assign refReq = owedNz || busy;

  // registered command pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN     <= 1'b1;
      rasN    <= 1'b1;
      casN    <= 1'b1;
      weN     <= 1'b1;
      a10     <= 1'b0;
      cke     <= 1'b1;
      refDone <= 1'b0;
    end else begin
      csN     <= !(strb.issuePre || strb.issueRef);
      rasN    <= !(strb.issuePre || strb.issueRef);
      casN    <= !strb.issueRef;
      weN     <= !strb.issuePre;
      a10     <= strb.issuePre;
      cke     <= 1'b1;
      refDone <= strb.finish;
    end
  end

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import refresh_seq_pkg::*;
#(
  parameter int INTERVAL = 780,
  parameter int T_RP     = 3,
  parameter int T_RC     = 9,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGnt,
  input  logic bankOpen,
  output logic refReq,
  output logic refDone,
  output logic csN,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic a10,
  output logic cke
);

  seqStrobe_t strb;
  logic       busy, owedNz;

  refresh_seq_ctrl #(.T_RP(T_RP), .T_RC(T_RC)) ctrl_i (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .bankOpen(bankOpen),
    .owedNz(owedNz), .strb(strb), .busy(busy)
  );

  refresh_seq_dp #(.INTERVAL(INTERVAL), .MAX_OWED(MAX_OWED)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .owedNz(owedNz),
    .refReq(refReq), .refDone(refDone), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .a10(a10), .cke(cke)
  );

endmodule

// File: rtl/refresh_seq_chk.sv
module refresh_seq_chk #(
  parameter int T_RP = 3,
  parameter int T_RC = 9
) (
  input logic clk,
  input logic rstN,
  input logic refReq,
  input logic refDone,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic a10,
  input logic cke
);

  localparam int GAP_CAP = T_RC + T_RP + 2;
  localparam int GAP_W   = $clog2(GAP_CAP + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_CAP);

  logic             isPre, isRef, isCmd;
  logic [GAP_W-1:0] refGap, preGap;
  logic             refSeen, afterPre;

  assign isCmd = !csN;
  assign isPre = !csN && !rasN && casN && !weN;
  assign isRef = !csN && !rasN && !casN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refGap   <= GAP_MAX;
      preGap   <= GAP_MAX;
      refSeen  <= 1'b0;
      afterPre <= 1'b0;
    end else begin
      if (isRef) begin
        refGap  <= GAP_W'(1);
        refSeen <= 1'b1;
      end else if (refGap != GAP_MAX) begin
        refGap <= refGap + 1'b1;
      end
      if (isPre)                 preGap <= GAP_W'(1);
      else if (preGap != GAP_MAX) preGap <= preGap + 1'b1;
      afterPre <= isPre ? 1'b1 : (isRef ? 1'b0 : afterPre);
    end
  end

  // R3
  cmd_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    isCmd |-> refReq);

  // R5
  pre_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    isPre |=> csN);

  // R5
  pre_to_ref_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRef && afterPre) |-> (preGap == GAP_W'(T_RP + 1)));

  // R6
  ref_encoding_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRef |-> (weN && cke && !a10));

  // R7
  ref_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isCmd && refSeen) |-> (refGap >= GAP_W'(T_RC)));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    refDone |=> !refDone);

  // R10
  done_req_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    refDone |-> !refReq);

endmodule

bind refresh_seq refresh_seq_chk #(.T_RP(T_RP), .T_RC(T_RC)) chk_i (
  .clk(clk), .rstN(rstN), .refReq(refReq), .refDone(refDone), .csN(csN),
  .rasN(rasN), .casN(casN), .weN(weN), .a10(a10), .cke(cke)
);

// File: tb/refresh_seq_tb_top.sv
module refresh_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 64;
  localparam int T_RP       = 2;
  localparam int T_RC       = 5;
  localparam int MAX_OWED   = 3;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    int open;
    int ticks;
    int pulse;
    int expRefs;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{0, 1, 0, 1},
    '{1, 1, 0, 1},
    '{1, 2, 0, 2},
    '{0, 3, 1, 3},
    '{1, 5, 0, 3},
    '{0, 1, 1, 1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGnt = 1'b0;
  logic bankOpen = 1'b0;
  logic refReq, refDone, csN, rasN, casN, weN, a10, cke;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit granted = 1'b0;

  int preCnt, refCnt, doneCnt, earlyCmd, badEnc;
  int preCyc, firstRef, lastRef, doneCyc, minGap, maxGap;
  bit reqAtDone;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc++;

  refresh_seq #(
    .INTERVAL(INTERVAL), .T_RP(T_RP), .T_RC(T_RC), .MAX_OWED(MAX_OWED)
  ) dut_i (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .bankOpen(bankOpen),
    .refReq(refReq), .refDone(refDone), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .a10(a10), .cke(cke)
  );

  // pin monitor, samples at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (!csN) begin
        if (!granted) earlyCmd++;
        if (!rasN && casN && !weN && a10) begin
          preCnt++;
          preCyc = cyc;
        end else if (!rasN && !casN && weN && !a10 && cke) begin
          if (refCnt != 0) begin
            if (cyc - lastRef < minGap) minGap = cyc - lastRef;
            if (cyc - lastRef > maxGap) maxGap = cyc - lastRef;
          end else begin
            firstRef = cyc;
          end
          lastRef = cyc;
          refCnt++;
        end else begin
          badEnc++;
        end
      end
      if (!cke) badEnc++;
      if (refDone) begin
        doneCnt++;
        doneCyc = cyc;
        reqAtDone = refReq;
      end
    end
  end

  task automatic checkEq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearStats();
    preCnt = 0; refCnt = 0; doneCnt = 0; earlyCmd = 0; badEnc = 0;
    preCyc = 0; firstRef = 0; lastRef = 0; doneCyc = 0;
    minGap = 1000; maxGap = 0; reqAtDone = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic checkResetPins(string tag);
    checkEq("R1", {tag, " csN"}, int'(csN), 1);
    checkEq("R1", {tag, " rasN/casN/weN"}, int'({rasN, casN, weN}), 7);
    checkEq("R1", {tag, " a10"}, int'(a10), 0);
    checkEq("R1", {tag, " cke"}, int'(cke), 1);
    checkEq("R1", {tag, " refReq/refDone"}, int'({refReq, refDone}), 0);
  endtask

  task automatic timeFirstRequest(string tag);
    int n = 0;
    while (!refReq) begin
      step();
      n++;
    end
    // R2: request visible INTERVAL cycles after reset release
    checkEq("R2", tag, n, INTERVAL);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog: actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clearStats();
    repeat (3) step();
    checkResetPins("in reset");
    rstN = 1'b1;
    timeFirstRequest("first request after reset");

    for (int v = 0; v < NVEC; v++) begin
      while (!refReq) step();
      clearStats();
      granted  = 1'b0;
      bankOpen = VECS[v].open[0];
      repeat ((VECS[v].ticks - 1) * INTERVAL + INTERVAL / 2) step();
      granted = 1'b1;
      refGnt  = 1'b1;
      step();
      // R11: grant withdrawn right after acceptance
      if (VECS[v].pulse != 0) refGnt = 1'b0;
      while (doneCnt == 0) step();
      refGnt = 1'b0;
      checkEq("R3", $sformatf("vec%0d commands before grant", v), earlyCmd, 0);
      checkEq("R8", $sformatf("vec%0d refresh count", v), refCnt, VECS[v].expRefs);
      if (VECS[v].ticks > MAX_OWED)
        checkEq("R9", $sformatf("vec%0d saturated count", v), refCnt, MAX_OWED);
      if (VECS[v].pulse != 0)
        checkEq("R11", $sformatf("vec%0d full burst after grant drop", v), refCnt, VECS[v].expRefs);
      checkEq("R4", $sformatf("vec%0d precharge count", v), preCnt, VECS[v].open);
      checkEq("R6", $sformatf("vec%0d bad encodings", v), badEnc, 0);
      if (VECS[v].open != 0)
        checkEq("R5", $sformatf("vec%0d precharge to refresh", v), firstRef - preCyc, T_RP + 1);
      if (VECS[v].expRefs > 1) begin
        checkEq("R7", $sformatf("vec%0d min refresh gap", v), minGap, T_RC);
        checkEq("R7", $sformatf("vec%0d max refresh gap", v), maxGap, T_RC);
      end
      checkEq("R10", $sformatf("vec%0d done pulses", v), doneCnt, 1);
      checkEq("R10", $sformatf("vec%0d done delay", v), doneCyc - lastRef, T_RC - 1);
      checkEq("R10", $sformatf("vec%0d request at done", v), int'(reqAtDone), 0);
    end

    // reset in the middle of a precharge sequence
    while (!refReq) step();
    clearStats();
    granted  = 1'b1;
    bankOpen = 1'b1;
    refGnt   = 1'b1;
    repeat (3) step();
    rstN = 1'b0;
    refGnt = 1'b0;
    #1;
    checkResetPins("async reset mid-sequence");
    step();
    checkResetPins("held reset");
    rstN = 1'b1;
    timeFirstRequest("first request after second reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule